// File: doc/BRIEF.md
# Region Access Guard

This block sits beside a processor's load/store path and decides, in the same cycle, whether each memory request may proceed. Eight programmable windows describe the memory the running task may touch. Each window has a start address, a length, an enable flag and a permission level. Software rewrites the windows through a small write-only configuration port, typically each time it switches from one task to another. Afterwards, every address the task issues is tested against that task's windows only.

A request is a valid strobe, an address and a read/write flag. The `allow` output is a purely combinational function of the request and the stored windows. A refused request produces a one-cycle `fault` pulse on the next clock. It also loads a sticky status record (address and access type), which stays in place until software acknowledges it. Translation, caching and the trap that software takes after a fault are handled elsewhere.

Top module: `mpu_guard`

## Requirements
- R1: After reset every window is disabled with permission code 0. Every valid request is therefore refused, and `fault` and `flt_valid` are low.
- R2: A window matches an address when base <= addr < base + size. The sum is evaluated without 32-bit wrap, so a window ending exactly at the top of the address space covers 0xFFFFFFFF. A window whose size is zero never matches.
- R3: The permission code is held in bits [2:1] of the control word. Code 0 refuses everything. Code 1 permits reads and refuses writes. Code 2 permits both. Code 3 behaves as code 0.
- R4: When several enabled windows match, only the one with the highest index decides, whether it grants more or less than a lower one.
- R5: A window whose enable bit (bit 0 of the control word) is clear never matches.
- R6: `allow` follows the request in the same cycle, with no register in between. With `req_valid` low, `allow` is 0 and no fault is raised.
- R7: `fault` is high for exactly the cycle after a cycle in which a valid request was refused, and low otherwise.
- R8: On a refusal while no fault is recorded, `flt_addr` and `flt_write` load the request's address and type, and `flt_valid` rises on the same edge as `fault`. Later refusals leave the record untouched while it is valid.
- R9: `flt_clr` drops `flt_valid` on the next edge. A refusal in the same cycle as `flt_clr` is recorded in place of the old fault.
- R10: Configuration writes use `cfg_idx` for the window, and `cfg_sel` for the field (0 base, 1 size, 2 control, 3 ignored). A write changes decisions from the following cycle, so windows can be rewritten at run time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 3 | Window selected for the write |
| cfg_sel | input | 2 | Field selected: 0 base, 1 size, 2 control |
| cfg_wdata | input | 32 | Write data (control: bit 0 enable, bits 2:1 permission) |
| req_valid | input | 1 | Memory request present |
| req_addr | input | 32 | Request address |
| req_write | input | 1 | 1 for a write, 0 for a read |
| allow | output | 1 | Request permitted (combinational) |
| fault | output | 1 | One-cycle pulse after a refused request |
| flt_valid | output | 1 | A fault record is held |
| flt_addr | output | 32 | Address of the recorded fault |
| flt_write | output | 1 | Access type of the recorded fault |
| flt_clr | input | 1 | Acknowledge and clear the fault record |

## Verification
The bench probes both edges of a window: one below the base, the base itself, the last byte, and one past the end. This catches an off-by-one compare that would admit or refuse the boundary byte. A window reaching the top of the address space catches a 32-bit sum that wraps and refuses everything in it. A zero-size window is probed at its own base, which a `<=` limit compare would wrongly admit. Overlapping windows are stacked so that the top one both narrows and widens the rights below it, which exposes a resolver that favours low indices or ORs the grants together. The fault record is attacked with a second refusal, which a design that overwrites would lose. It is also attacked with a clear coinciding with a refusal, which a design giving the clear priority would drop.

// File: rtl/mpu_pkg.sv
package mpu_pkg;
  parameter int unsigned ADDR_W = 32;

  typedef enum logic [1:0] {
    PERM_NONE = 2'd0,
    PERM_RO   = 2'd1,
    PERM_RW   = 2'd2,
    PERM_RSVD = 2'd3
  } perm_t;

  typedef enum logic [1:0] {
    SEL_BASE = 2'd0,
    SEL_SIZE = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_NONE = 2'd3
  } cfg_sel_t;

  typedef struct packed {
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] size;
    logic              en;
    perm_t             perm;
  } region_cfg_t;

  // Window containment with one guard bit so base+size cannot wrap.
  function automatic logic addr_in_window(input logic [ADDR_W-1:0] base,
                                          input logic [ADDR_W-1:0] size,
                                          input logic [ADDR_W-1:0] addr);
    logic [ADDR_W:0] limit;
    limit = {1'b0, base} + {1'b0, size};
    return (size != '0) && (addr >= base) && ({1'b0, addr} < limit);
  endfunction

  // Does a permission level admit this access type.
  function automatic logic perm_grants(input perm_t p, input logic is_write);
    case (p)
      PERM_RO: return !is_write;
      PERM_RW: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/mpu_cfg_regs.sv
module mpu_cfg_regs
  import mpu_pkg::*;
#(
  parameter int unsigned NREG  = 8,
  parameter int unsigned IDX_W = $clog2(NREG)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [IDX_W-1:0]        idx,
  input  logic [1:0]              sel,
  input  logic [ADDR_W-1:0]       wdata,
  output region_cfg_t [NREG-1:0]  regions_o
);
  for (genvar r = 0; r < NREG; r++) begin : g_reg
    logic hit_w;
    assign hit_w = we && (idx == IDX_W'(r));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regions_o[r] <= '0;
      end else if (hit_w) begin
        case (cfg_sel_t'(sel))
          SEL_BASE: regions_o[r].base <= wdata;
          SEL_SIZE: regions_o[r].size <= wdata;
          SEL_CTRL: begin
            regions_o[r].en   <= wdata[0];
            regions_o[r].perm <= perm_t'(wdata[2:1]);
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/mpu_region_match.sv
module mpu_region_match
  import mpu_pkg::*;
(
  input  region_cfg_t       cfg,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  assign hit = cfg.en && addr_in_window(cfg.base, cfg.size, addr);
endmodule

// File: rtl/mpu_fault_latch.sv
module mpu_fault_latch
  import mpu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              deny,
  input  logic [ADDR_W-1:0] addr,
  input  logic              is_write,
  input  logic              clr,
  output logic              fault,
  output logic              rec_valid,
  output logic [ADDR_W-1:0] rec_addr,
  output logic              rec_write
);
  logic take;
  assign take = deny && (!rec_valid || clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault     <= 1'b0;
      rec_valid <= 1'b0;
      rec_addr  <= '0;
      rec_write <= 1'b0;
    end else begin
      fault <= deny;
      if (take) begin
        rec_valid <= 1'b1;
        rec_addr  <= addr;
        rec_write <= is_write;
      end else if (clr) begin
        rec_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mpu_guard.sv
module mpu_guard
  import mpu_pkg::*;
#(
  parameter int unsigned NREG  = 8,
  parameter int unsigned IDX_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [1:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  output logic              allow,
  output logic              fault,
  output logic              flt_valid,
  output logic [ADDR_W-1:0] flt_addr,
  output logic              flt_write,
  input  logic              flt_clr
);
  region_cfg_t [NREG-1:0] regions;
  logic [NREG-1:0]        hit_vec;
  logic                   win_hit;
  perm_t                  win_perm;
  logic                   deny;

  mpu_cfg_regs #(.NREG(NREG), .IDX_W(IDX_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .idx(cfg_idx), .sel(cfg_sel),
    .wdata(cfg_wdata), .regions_o(regions)
  );

  for (genvar r = 0; r < NREG; r++) begin : g_match
    mpu_region_match u_match (
      .cfg(regions[r]), .addr(req_addr), .hit(hit_vec[r])
    );
  end

  // Ascending scan: a later (higher) index overrides earlier hits.
  always_comb begin
    win_hit  = 1'b0;
    win_perm = PERM_NONE;
    for (int r = 0; r < NREG; r++) begin
      if (hit_vec[r]) begin
        win_hit  = 1'b1;
        win_perm = regions[r].perm;
      end
    end
  end

  assign allow = req_valid && win_hit && perm_grants(win_perm, req_write);
  assign deny  = req_valid && !allow;

  mpu_fault_latch u_flt (
    .clk(clk), .rst_n(rst_n), .deny(deny), .addr(req_addr),
    .is_write(req_write), .clr(flt_clr), .fault(fault),
    .rec_valid(flt_valid), .rec_addr(flt_addr), .rec_write(flt_write)
  );
endmodule

// File: rtl/mpu_guard_chk.sv
module mpu_guard_chk
  import mpu_pkg::*;
#(
  parameter int unsigned NREG = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_addr,
  input logic              req_write,
  input logic              allow,
  input logic              fault,
  input logic              flt_valid,
  input logic [ADDR_W-1:0] flt_addr,
  input logic              flt_write,
  input logic              flt_clr,
  input logic [NREG-1:0]   hit_vec,
  input perm_t             win_perm
);
  AST_IDLE_NO_ALLOW: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> !allow); // R6
  AST_ALLOW_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    allow |-> (hit_vec != '0)); // R2
  AST_WRITE_NEEDS_RW: assert property (@(posedge clk) disable iff (!rst_n)
    (allow && req_write) |-> (win_perm == PERM_RW)); // R3
  AST_READ_NEEDS_PERM: assert property (@(posedge clk) disable iff (!rst_n)
    (allow && !req_write) |-> (win_perm == PERM_RO || win_perm == PERM_RW)); // R3
  AST_FAULT_AFTER_DENY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !allow) |=> fault); // R7
  AST_NO_SPURIOUS_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !allow) |=> !fault); // R7
  AST_RECORD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !allow && (!flt_valid || flt_clr)) |=>
      (flt_valid && flt_addr == $past(req_addr) && flt_write == $past(req_write))); // R8
  AST_RECORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_valid && !flt_clr) |=> (flt_valid && $stable(flt_addr) && $stable(flt_write))); // R8
  AST_RECORD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_clr && !(req_valid && !allow)) |=> !flt_valid); // R9
endmodule

bind mpu_guard mpu_guard_chk #(.NREG(NREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
  .req_write(req_write), .allow(allow), .fault(fault), .flt_valid(flt_valid),
  .flt_addr(flt_addr), .flt_write(flt_write), .flt_clr(flt_clr),
  .hit_vec(hit_vec), .win_perm(win_perm)
);

// File: tb/mpu_guard_tb.sv
module mpu_guard_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_idx = '0;
  logic [1:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic        flt_clr = 1'b0;
  logic        allow, fault, flt_valid, flt_write;
  logic [31:0] flt_addr;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  mpu_guard u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .req_valid(req_valid),
    .req_addr(req_addr), .req_write(req_write), .allow(allow), .fault(fault),
    .flt_valid(flt_valid), .flt_addr(flt_addr), .flt_write(flt_write),
    .flt_clr(flt_clr)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  // Control word: bit 0 enable, bits 2:1 permission code.
  task automatic set_window(input int idx, input logic [31:0] base, input logic [31:0] size,
                            input logic en, input logic [1:0] perm);
    @(negedge clk); cfg_we = 1; cfg_idx = 3'(idx); cfg_sel = 2'd0; cfg_wdata = base;
    @(negedge clk); cfg_sel = 2'd1; cfg_wdata = size;
    @(negedge clk); cfg_sel = 2'd2; cfg_wdata = {29'd0, perm, en};
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic set_ctrl(input int idx, input logic en, input logic [1:0] perm);
    @(negedge clk); cfg_we = 1; cfg_idx = 3'(idx); cfg_sel = 2'd2; cfg_wdata = {29'd0, perm, en};
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic probe(input logic [31:0] a, input logic w, input logic exp, input string tag);
    @(negedge clk); req_valid = 1; req_addr = a; req_write = w;
    #1 chk(32'(allow), 32'(exp), {tag, " allow"});
    @(negedge clk); req_valid = 0;
    #1 chk(32'(fault), 32'(!exp), {tag, " fault"});
  endtask

  task automatic clear_rec();
    @(negedge clk); flt_clr = 1;
    @(negedge clk); flt_clr = 0;
  endtask

  task automatic t_reset();
    #1 chk(32'(allow), 0, "R1 idle allow");
    chk(32'(fault), 0, "R1 fault at reset");
    chk(32'(flt_valid), 0, "R1 record at reset");
    probe(32'h0000_0000, 0, 0, "R1 read at 0");
    probe(32'h0000_1000, 1, 0, "R1 write at 0x1000");
    clear_rec();
  endtask

  task automatic t_range();
    set_window(0, 32'h1000, 32'h100, 1, 2'd2);
    probe(32'h0FFF, 0, 0, "R2 below base");
    probe(32'h1000, 1, 1, "R2 at base");
    probe(32'h10FF, 0, 1, "R2 last byte");
    probe(32'h1100, 0, 0, "R2 one past end");
    set_window(1, 32'h2000, 32'h0, 1, 2'd2);
    probe(32'h2000, 0, 0, "R2 zero size");
    set_window(2, 32'hFFFF_FF00, 32'h100, 1, 2'd2);
    probe(32'hFFFF_FFFF, 1, 1, "R2 top of space");
    probe(32'h0000_0000, 0, 0, "R2 no wrap to zero");
  endtask

  task automatic t_perm();
    set_window(3, 32'h3000, 32'h100, 1, 2'd1);
    probe(32'h3010, 0, 1, "R3 read-only read");
    probe(32'h3010, 1, 0, "R3 read-only write");
    set_ctrl(3, 1, 2'd0);
    probe(32'h3010, 0, 0, "R3/R10 none after rewrite");
    set_ctrl(3, 1, 2'd3);
    probe(32'h3010, 0, 0, "R3 code 3 read");
    set_ctrl(3, 1, 2'd2);
    probe(32'h3010, 1, 1, "R3/R10 read-write write");
  endtask

  task automatic t_prio();
    set_window(5, 32'h1080, 32'h10, 1, 2'd1);
    probe(32'h1088, 1, 0, "R4 higher RO narrows");
    probe(32'h1088, 0, 1, "R4 higher RO read");
    probe(32'h1000, 1, 1, "R4 outside overlap");
    set_window(6, 32'h1080, 32'h4, 1, 2'd0);
    probe(32'h1081, 0, 0, "R4 top none wins");
    probe(32'h1084, 0, 1, "R4 below top window");
    set_window(7, 32'h1082, 32'h1, 1, 2'd2);
    probe(32'h1082, 1, 1, "R4 top RW widens");
  endtask

  task automatic t_disable();
    set_ctrl(0, 0, 2'd2);
    probe(32'h1000, 0, 0, "R5 disabled window");
    probe(32'h10F0, 1, 0, "R5 disabled window write");
    set_ctrl(0, 1, 2'd2);
    probe(32'h10F0, 1, 1, "R5/R10 re-enabled");
  endtask

  task automatic t_idle();
    clear_rec();
    @(negedge clk); req_valid = 0; req_addr = 32'h9999; req_write = 1;
    #1 chk(32'(allow), 0, "R6 idle allow");
    @(negedge clk);
    #1 chk(32'(fault), 0, "R6 idle no fault");
    chk(32'(flt_valid), 0, "R6 idle no record");
  endtask

  task automatic t_record();
    clear_rec();
    probe(32'h9000, 1, 0, "R7 first refusal");
    chk(32'(flt_valid), 1, "R8 record valid");
    chk(flt_addr, 32'h9000, "R8 record addr");
    chk(32'(flt_write), 1, "R8 record type");
    probe(32'hA000, 0, 0, "R8 second refusal");
    chk(flt_addr, 32'h9000, "R8 addr kept");
    chk(32'(flt_write), 1, "R8 type kept");
    clear_rec();
    #1 chk(32'(flt_valid), 0, "R9 cleared");
    probe(32'hC000, 0, 0, "R9 refusal after clear");
    @(negedge clk); flt_clr = 1; req_valid = 1; req_addr = 32'hB000; req_write = 0;
    #1 chk(32'(allow), 0, "R9 concurrent refusal");
    @(negedge clk); flt_clr = 0; req_valid = 0;
    #1 chk(32'(flt_valid), 1, "R9 clear+refusal valid");
    chk(flt_addr, 32'hB000, "R9 clear+refusal addr");
    chk(32'(flt_write), 0, "R9 clear+refusal type");
    chk(32'(fault), 1, "R7 pulse on concurrent");
    @(negedge clk);
    #1 chk(32'(fault), 0, "R7 pulse one cycle");
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected below 50000 cycles", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_range();
    t_perm();
    t_prio();
    t_disable();
    t_idle();
    t_record();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule